// File: doc/BRIEF.md
# Virtually-Indexed Physically-Tagged L1 Data Cache Lookup

This block is the lookup stage of a 16 KB, four-way set-associative L1 data cache with 32-byte lines. A load offers only the untranslated low twelve bits of its virtual address. Those bits cover the 7-bit set index, the 3-bit word select and the 2-bit byte position, so the block captures the set and word at request time. The address translator meanwhile produces the physical page number. In the following cycle the physical page number is compared with the four stored tags of the set. A hit returns the addressed 32-bit word. A miss raises a line request toward the next level.

If the translator cannot answer, the request waits in the second stage and new requests are refused until an answer comes. If the answer is a translation miss, the request is dropped with no lookup result. The next level returns lines through the fill port. Each fill goes into the way that already holds the same line. If there is no such way, it goes into the lowest-numbered empty way. If the set is full, a per-set tree pseudo-LRU picks the way.

Top module: `vipt_l1_lookup`

## Requirements
- R1: After reset no line is valid, so every lookup resolved after reset and before any fill reports a miss.
- R2: A request's page offset `req_voff` is split as set = bits [11:5], word = bits [4:2]; bits [1:0] have no effect; the tag compared is the full `xlat_ppn`, so a different page number or a different set misses.
- R3: A request accepted on a clock edge (`req_valid` and `req_ready` high) is answered in the first cycle in which `xlat_valid` is high. A new request may be accepted in that same cycle, so back-to-back lookups are one cycle apart.
- R4: On a hit, `rsp_word` equals bits [32k+31:32k] of the filled line, where k is the word select.
- R5: On a miss, `miss_valid` rises in the response cycle with `rsp_hit` low and `miss_paddr` = {page number, set, five zero bits}; `miss_valid` never rises outside a response.
- R6: When `xlat_valid` and `xlat_miss` are both high for a waiting request, neither `rsp_valid` nor `miss_valid` rises, and the request is retired.
- R7: While a request waits and `xlat_valid` is low, `req_ready` is low, no response appears, and the held request does not change.
- R8: A fill of a line that is not present goes into the lowest-numbered invalid way of its set when one exists, and it evicts nothing.
- R9: In a full set a fill replaces the way chosen by a three-bit tree per set. The root bit chooses the half (0: ways 0-1, 1: ways 2-3) and a leaf bit chooses the way within the half. Every hit and every fill points the bits on its path away from the way it used.
- R10: A fill of a line already present overwrites that same way, so the old data is replaced and no other line of the set is lost.
- R11: A line filled on an edge is found by any lookup resolved after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Stage can take a request this cycle |
| req_voff | input | 12 | Untranslated page-offset bits of the load address |
| xlat_valid | input | 1 | Translation answer present for the waiting request |
| xlat_miss | input | 1 | Translation failed; drop the waiting request |
| xlat_ppn | input | 20 | Physical page number from translation |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Result is a hit |
| rsp_word | output | 32 | Addressed word on a hit |
| miss_valid | output | 1 | Line request toward next level |
| miss_paddr | output | 32 | Line-aligned physical address of the missing line |
| fill_valid | input | 1 | Line fill present |
| fill_ppn | input | 20 | Page number (tag) of the filled line |
| fill_set | input | 7 | Set of the filled line |
| fill_line | input | 256 | Line data, word 0 in the low bits |

## Verification
The hardest case to reach is a replacement decided by the tree rather than by an empty way. This needs a full set whose tree bits have been moved by a known order of hits. The stimulus fills four lines into one set, so the empty-way rule places them in ways 0 to 3. It then hits them in a fixed order, which leaves the tree pointing at way 2. It fills two more lines and checks through ordinary lookups that exactly the lines from way 2 and then way 0 have gone. A refill of a resident line with new data then shows that the line stays in its own way and that its neighbours survive.

// File: rtl/vipt_l1_pkg.sv
package vipt_l1_pkg;

    parameter int unsigned PAGE_OFF_W = 12;
    parameter int unsigned PPN_W      = 20;
    parameter int unsigned SETS       = 128;
    parameter int unsigned WAYS       = 4;
    parameter int unsigned LINE_BYTES = 32;
    parameter int unsigned WORD_BYTES = 4;

    localparam int unsigned IDX_W  = $clog2(SETS);
    localparam int unsigned OFF_W  = $clog2(LINE_BYTES);
    localparam int unsigned WORDS  = LINE_BYTES / WORD_BYTES;
    localparam int unsigned WSEL_W = $clog2(WORDS);
    localparam int unsigned BSEL_W = $clog2(WORD_BYTES);
    localparam int unsigned WAY_W  = $clog2(WAYS);
    localparam int unsigned TREE_W = WAYS - 1;
    localparam int unsigned LINE_W = LINE_BYTES * 8;
    localparam int unsigned WORD_W = WORD_BYTES * 8;
    localparam int unsigned PA_W   = PPN_W + PAGE_OFF_W;

    typedef logic [PPN_W-1:0]  ppn_t;
    typedef logic [IDX_W-1:0]  set_t;
    typedef logic [WAY_W-1:0]  way_t;
    typedef logic [WAYS-1:0]   wayvec_t;
    typedef logic [TREE_W-1:0] tree_t;
    typedef logic [LINE_W-1:0] line_t;
    typedef logic [WORD_W-1:0] word_t;

    // Lookup address held between the index cycle and the compare cycle
    typedef struct packed {
        set_t              set;
        logic [WSEL_W-1:0] word;
    } lk_addr_t;

    // Binary position of the set bit in a one-hot (or zero) vector
    function automatic way_t onehot_to_way(wayvec_t v);
        way_t r = '0;
        for (int w = 0; w < int'(WAYS); w++)
            if (v[w]) r = r | way_t'(w);
        return r;
    endfunction

    // Walk the heap-ordered tree (node n at bit n-1) toward the victim
    function automatic way_t tree_victim(tree_t t);
        int unsigned n = 1;
        for (int l = 0; l < int'(WAY_W); l++)
            n = 2 * n + int'(t[n-1]);
        return way_t'(n - WAYS);
    endfunction

    // Point every node on the path of the used way away from it
    function automatic tree_t tree_touch(tree_t t, way_t used);
        tree_t       r = t;
        int unsigned n = 1;
        for (int l = 0; l < int'(WAY_W); l++) begin
            r[n-1] = ~used[WAY_W-1-l];
            n = 2 * n + int'(used[WAY_W-1-l]);
        end
        return r;
    endfunction

endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store
    import vipt_l1_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  set_t    lk_set,
    input  ppn_t    lk_ppn,
    output wayvec_t lk_hit,
    input  logic    fl_en,
    input  set_t    fl_set,
    input  ppn_t    fl_ppn,
    input  way_t    fl_way,
    output wayvec_t fl_valid,
    output wayvec_t fl_match
);

    wayvec_t vld_q [SETS];
    ppn_t    tag_q [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < int'(SETS); s++) vld_q[s] <= '0;
        end else if (fl_en) begin
            vld_q[fl_set][fl_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fl_en) tag_q[fl_set][fl_way] <= fl_ppn;
    end

    for (genvar w = 0; w < int'(WAYS); w++) begin : g_way
        assign lk_hit[w]   = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_ppn);
        assign fl_match[w] = vld_q[fl_set][w] && (tag_q[fl_set][w] == fl_ppn);
        assign fl_valid[w] = vld_q[fl_set][w];
    end

    // R10: refills reuse their way, so a line never sits in two ways
    a_r10_single_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_hit));

endmodule

// File: rtl/vipt_plru.sv
module vipt_plru
    import vipt_l1_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    touch_en,
    input  set_t    touch_set,
    input  way_t    touch_way,
    input  set_t    q_set,
    input  wayvec_t q_valid,
    input  wayvec_t q_match,
    output way_t    victim
);

    tree_t tree_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < int'(SETS); s++) tree_q[s] <= '0;
        end else if (touch_en) begin
            tree_q[touch_set] <= tree_touch(tree_q[touch_set], touch_way);
        end
    end

    always_comb begin
        if (|q_match) begin
            victim = onehot_to_way(q_match);
        end else if (!(&q_valid)) begin
            victim = '0;
            for (int w = int'(WAYS) - 1; w >= 0; w--)
                if (!q_valid[w]) victim = way_t'(w);
        end else begin
            victim = tree_victim(tree_q[q_set]);
        end
    end

    // R8: with a free way and no resident copy, never overwrite a valid line
    a_r8_free_way_first: assert property (@(posedge clk) disable iff (rst)
        (!(&q_valid) && !(|q_match)) |-> !q_valid[victim]);

endmodule

// File: rtl/vipt_data_store.sv
module vipt_data_store
    import vipt_l1_pkg::*;
(
    input  logic              clk,
    input  logic              wr_en,
    input  set_t              wr_set,
    input  way_t              wr_way,
    input  line_t             wr_line,
    input  set_t              rd_set,
    input  way_t              rd_way,
    input  logic [WSEL_W-1:0] rd_word,
    output word_t             rd_data
);

    line_t line_q [SETS][WAYS];
    line_t sel_line;

    always_ff @(posedge clk) begin
        if (wr_en) line_q[wr_set][wr_way] <= wr_line;
    end

    assign sel_line = line_q[rd_set][rd_way];
    assign rd_data  = sel_line[WORD_W*int'(rd_word) +: WORD_W];

endmodule

// File: rtl/vipt_l1_lookup.sv
module vipt_l1_lookup
    import vipt_l1_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [PAGE_OFF_W-1:0] req_voff,
    input  logic                  xlat_valid,
    input  logic                  xlat_miss,
    input  logic [PPN_W-1:0]      xlat_ppn,
    output logic                  rsp_valid,
    output logic                  rsp_hit,
    output logic [WORD_W-1:0]     rsp_word,
    output logic                  miss_valid,
    output logic [PA_W-1:0]       miss_paddr,
    input  logic                  fill_valid,
    input  logic [PPN_W-1:0]      fill_ppn,
    input  logic [IDX_W-1:0]      fill_set,
    input  logic [LINE_W-1:0]     fill_line
);

    lk_addr_t s2_q;
    logic     s2_valid_q;
    lk_addr_t req_addr;
    logic     accept, resolve, any_hit;
    wayvec_t  hit_vec, fl_valid, fl_match;
    way_t     hit_way, fill_way, touch_way;
    logic     unused_byte_bits;

    // Index cycle: only page-offset bits are needed, translation runs alongside
    assign req_addr.set     = req_voff[PAGE_OFF_W-1:OFF_W];
    assign req_addr.word    = req_voff[OFF_W-1:BSEL_W];
    assign unused_byte_bits = ^req_voff[BSEL_W-1:0];

    assign resolve   = s2_valid_q && xlat_valid;
    assign req_ready = !s2_valid_q || xlat_valid;
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_valid_q <= 1'b0;
            s2_q       <= '0;
        end else if (accept) begin
            s2_valid_q <= 1'b1;
            s2_q       <= req_addr;
        end else if (resolve) begin
            s2_valid_q <= 1'b0;
        end
    end

    vipt_tag_store u_tags (
        .clk      (clk),
        .rst      (rst),
        .lk_set   (s2_q.set),
        .lk_ppn   (xlat_ppn),
        .lk_hit   (hit_vec),
        .fl_en    (fill_valid),
        .fl_set   (fill_set),
        .fl_ppn   (fill_ppn),
        .fl_way   (fill_way),
        .fl_valid (fl_valid),
        .fl_match (fl_match)
    );

    assign any_hit = |hit_vec;
    assign hit_way = onehot_to_way(hit_vec);

    vipt_data_store u_data (
        .clk     (clk),
        .wr_en   (fill_valid),
        .wr_set  (fill_set),
        .wr_way  (fill_way),
        .wr_line (fill_line),
        .rd_set  (s2_q.set),
        .rd_way  (hit_way),
        .rd_word (s2_q.word),
        .rd_data (rsp_word)
    );

    // Compare cycle outputs
    assign rsp_valid  = resolve && !xlat_miss;
    assign rsp_hit    = rsp_valid && any_hit;
    assign miss_valid = rsp_valid && !any_hit;
    assign miss_paddr = {xlat_ppn, s2_q.set, {OFF_W{1'b0}}};

    // Fill placement wins the replacement update over a same-cycle hit
    assign touch_way = fill_valid ? fill_way : hit_way;

    vipt_plru u_repl (
        .clk       (clk),
        .rst       (rst),
        .touch_en  (fill_valid || rsp_hit),
        .touch_set (fill_valid ? fill_set : s2_q.set),
        .touch_way (touch_way),
        .q_set     (fill_set),
        .q_valid   (fl_valid),
        .q_match   (fl_match),
        .victim    (fill_way)
    );

    // R1: the first cycle out of reset cannot report a hit
    a_r1_cold_no_hit: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rsp_hit);

    // R5: a line request only accompanies a missing response
    a_r5_miss_in_response: assert property (@(posedge clk) disable iff (rst)
        miss_valid |-> (rsp_valid && !rsp_hit));

    // R6: a failed translation yields neither a result nor a line request
    a_r6_xlat_drop: assert property (@(posedge clk) disable iff (rst)
        (xlat_valid && xlat_miss) |-> (!rsp_valid && !miss_valid));

    // R7: a waiting request stays put until translation answers
    a_r7_hold_waiting: assert property (@(posedge clk) disable iff (rst)
        (s2_valid_q && !xlat_valid) |=> (s2_valid_q && $stable(s2_q)));

endmodule

// File: tb/tb_vipt_l1_lookup.sv
module tb_vipt_l1_lookup;
    import vipt_l1_pkg::*;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  req_valid = 1'b0;
    logic                  req_ready;
    logic [PAGE_OFF_W-1:0] req_voff = '0;
    logic                  xlat_valid = 1'b0;
    logic                  xlat_miss = 1'b0;
    logic [PPN_W-1:0]      xlat_ppn = '0;
    logic                  rsp_valid, rsp_hit, miss_valid;
    logic [WORD_W-1:0]     rsp_word;
    logic [PA_W-1:0]       miss_paddr;
    logic                  fill_valid = 1'b0;
    logic [PPN_W-1:0]      fill_ppn = '0;
    logic [IDX_W-1:0]      fill_set = '0;
    logic [LINE_W-1:0]     fill_line = '0;

    always #4 clk = ~clk;

    vipt_l1_lookup dut (.*);

    typedef struct {
        bit               hit;
        logic [31:0]      word;
        logic [PA_W-1:0]  paddr;
        string            req;
    } exp_t;

    exp_t                       sb_q[$];
    logic [LINE_W-1:0]          lines [logic [PPN_W+IDX_W-1:0]];
    int                         checks = 0;
    int                         fails  = 0;
    bit                         done   = 0;

    function automatic void chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endfunction

    function automatic logic [LINE_W-1:0] mk_line(logic [PPN_W-1:0] ppn, logic [IDX_W-1:0] set,
                                                  logic [15:0] salt);
        logic [LINE_W-1:0] l;
        for (int k = 0; k < int'(WORDS); k++)
            l[k*32 +: 32] = {ppn[15:0] ^ salt, 1'b0, set, 5'b0, 3'(k)};
        return l;
    endfunction

    function automatic exp_t mk_exp(logic [PPN_W-1:0] ppn, logic [IDX_W-1:0] set, int word,
                                    string req);
        exp_t e;
        logic [PPN_W+IDX_W-1:0] key = {ppn, set};
        e.hit   = lines.exists(key);
        e.word  = e.hit ? lines[key][32*word +: 32] : '0;
        e.paddr = {ppn, set, 5'b0};
        e.req   = req;
        return e;
    endfunction

    // Monitor: pops the scoreboard whenever the design answers
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #2;
            if (rsp_valid) begin
                if (sb_q.size() == 0) begin
                    chk(0, "R3 unexpected response", 1, 0);
                end else begin
                    e = sb_q.pop_front();
                    chk(rsp_hit == e.hit, {e.req, " hit"}, rsp_hit, e.hit);
                    if (e.hit) chk(rsp_word == e.word, {e.req, " R4 word"}, rsp_word, e.word);
                    chk(miss_valid == !e.hit, {e.req, " R5 miss flag"}, miss_valid, !e.hit);
                    if (!e.hit) chk(miss_paddr == e.paddr, {e.req, " R5 paddr"}, miss_paddr, e.paddr);
                end
            end else if (miss_valid) begin
                chk(0, "R5 miss outside response", 1, 0);
            end
        end
    end

    task automatic fill(input logic [PPN_W-1:0] ppn, input logic [IDX_W-1:0] set,
                        input logic [15:0] salt);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_ppn   = ppn;
        fill_set   = set;
        fill_line  = mk_line(ppn, set, salt);
        lines[{ppn, set}] = fill_line;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic lookup(input logic [PPN_W-1:0] ppn, input logic [IDX_W-1:0] set,
                          input int word, input int boff, input bit xmiss, input int delay,
                          input string req);
        @(negedge clk);
        req_valid = 1'b1;
        req_voff  = {set, 3'(word), 2'(boff)};
        #1 chk(req_ready == 1'b1, "R7 ready when idle", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < delay; i++) begin
            #1 chk(!req_ready && !rsp_valid, "R7 stall", {req_ready, rsp_valid}, 0);
            @(negedge clk);
        end
        if (!xmiss) sb_q.push_back(mk_exp(ppn, set, word, req));
        xlat_valid = 1'b1;
        xlat_miss  = xmiss;
        xlat_ppn   = ppn;
        #3;
        if (xmiss) chk(!rsp_valid && !miss_valid, "R6 dropped", {rsp_valid, miss_valid}, 0);
        else       chk(rsp_valid, "R3 answer in xlat cycle", rsp_valid, 1);
        @(negedge clk);
        xlat_valid = 1'b0;
        xlat_miss  = 1'b0;
    endtask

    initial begin
        #800000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1 chk(!rsp_valid && !miss_valid && req_ready, "R1 reset outputs",
               {rsp_valid, miss_valid, req_ready}, 3'b001);

        // R1 / R5: cold cache misses with a line-aligned request
        lookup(20'h12345, 7'd3, 5, 1, 0, 0, "R1");

        // R11 / R4 / R2: fill then read every word with varied byte bits
        fill(20'h12345, 7'd3, 16'h0);
        for (int w = 0; w < int'(WORDS); w++) lookup(20'h12345, 7'd3, w, w % 4, 0, 0, "R11");

        // R2: other page number or other set misses
        lookup(20'h12346, 7'd3, 0, 0, 0, 0, "R2");
        lookup(20'h12345, 7'd4, 0, 0, 0, 0, "R2");

        // R8: four lines fill ways 0..3 in order, all resident
        fill(20'h00100, 7'd9, 16'h0);
        fill(20'h00101, 7'd9, 16'h0);
        fill(20'h00102, 7'd9, 16'h0);
        fill(20'h00103, 7'd9, 16'h0);
        lookup(20'h00100, 7'd9, 1, 0, 0, 0, "R8");
        lookup(20'h00102, 7'd9, 2, 0, 0, 0, "R8");
        lookup(20'h00103, 7'd9, 3, 0, 0, 0, "R8");
        lookup(20'h00101, 7'd9, 4, 0, 0, 0, "R8");

        // R9: tree now points at way 2 (line 102), then at way 0 (line 100)
        fill(20'h00104, 7'd9, 16'h0);
        lines.delete({20'h00102, 7'd9});
        fill(20'h00105, 7'd9, 16'h0);
        lines.delete({20'h00100, 7'd9});
        lookup(20'h00100, 7'd9, 0, 0, 0, 0, "R9");
        lookup(20'h00102, 7'd9, 0, 0, 0, 0, "R9");
        lookup(20'h00101, 7'd9, 6, 0, 0, 0, "R9");
        lookup(20'h00103, 7'd9, 7, 0, 0, 0, "R9");
        lookup(20'h00104, 7'd9, 0, 0, 0, 0, "R9");
        lookup(20'h00105, 7'd9, 5, 0, 0, 0, "R9");

        // R10: refill of a resident line with new data keeps neighbours
        fill(20'h00101, 7'd9, 16'h5a5a);
        lookup(20'h00101, 7'd9, 5, 0, 0, 0, "R10");
        lookup(20'h00103, 7'd9, 1, 0, 0, 0, "R10");
        lookup(20'h00104, 7'd9, 2, 0, 0, 0, "R10");
        lookup(20'h00105, 7'd9, 3, 0, 0, 0, "R10");

        // R6: translation failure drops the request; the next one works
        lookup(20'h00101, 7'd9, 2, 0, 1, 0, "R6");
        lookup(20'h00101, 7'd9, 2, 0, 0, 0, "R6");

        // R7: translation late by three cycles
        lookup(20'h00103, 7'd9, 6, 3, 0, 3, "R7");

        // R3: back-to-back requests, one per cycle
        @(negedge clk);
        req_valid = 1'b1;
        req_voff  = {7'd9, 3'd1, 2'd0};
        @(negedge clk);
        sb_q.push_back(mk_exp(20'h00104, 7'd9, 1, "R3"));
        req_voff   = {7'd9, 3'd7, 2'd0};
        xlat_valid = 1'b1;
        xlat_ppn   = 20'h00104;
        #1 chk(req_ready, "R3 ready in answer cycle", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        sb_q.push_back(mk_exp(20'h00105, 7'd9, 7, "R3"));
        xlat_ppn  = 20'h00105;
        @(negedge clk);
        xlat_valid = 1'b0;

        repeat (4) @(negedge clk);
        chk(sb_q.size() == 0, "R3 all responses seen", sb_q.size(), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule